// File: doc/BRIEF.md
# Lower-Half RAM Window Translator

This block converts a 16-bit address from an 8-bit processor into a 17-bit physical address for a 128KB main RAM, covering only the lower 32KB of the processor's map. Two 8-bit selector registers control the translation. The first selector covers the bottom 512 bytes (zero page and stack) and replaces the high physical bits outright. The second selector sets the base of a sliding window over the rest of the lower half. The block shifts that selector left by nine bits and adds it to the low 15 address bits.

Software writes the selectors through one I/O slot. An external decoder supplies the slot select. A write commits when the processor's phase-2 strobe falls, and the block detects that fall on its own system clock. Both selectors can be read back. The block also drives a RAM enable, which is asserted only for lower-half accesses while phase 2 is high.

Top module: `lowmem_window_mapper`

## Requirements
- R1: Reset (rstN low) clears both selectors to zero. CPU addresses $0000-$7FFF then map to the identical physical addresses $00000-$07FFF.
- R2: For CPU addresses $0000-$01FF, ramAddr equals the page selector in bits 16:9, concatenated with CPU address bits 8:0. No addition is involved.
- R3: For CPU addresses $0200-$7FFF, ramAddr equals (window selector × 512 + CPU address bits 14:0) modulo 2^17. The $200 offset is not subtracted.
- R4: When both selectors hold the same value N, CPU $0000-$7FFF maps onto the contiguous physical range that starts at N×512.
- R5: Window selector values $C1 and above wrap the top of the window to the bottom of RAM. Values $C0 and below never wrap, so ramAddr is never below selector×512.
- R6: A register write commits on the first system-clock edge after cpuPhi2 falls, provided ioSlotSel is 1 and cpuRnW is 0 at that edge. CPU address bit 0 selects the target: 0 writes the page selector and 1 writes the window selector. All other address bits are ignored, so those offsets alias onto the two registers.
- R7: No selector changes when cpuRnW is 1, when ioSlotSel is 0, or while cpuPhi2 stays high.
- R8: regRdData always shows the selector picked by CPU address bit 0, using the same encoding as R6.
- R9: ramEn is 1 exactly when CPU address bit 15 is 0 and cpuPhi2 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the phase-2 strobe |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | Processor address bus |
| cpuDataIn | input | 8 | Processor write data |
| cpuRnW | input | 1 | 1 = read, 0 = write |
| cpuPhi2 | input | 1 | Processor phase-2 strobe |
| ioSlotSel | input | 1 | Selector slot chosen by the I/O decoder |
| ramAddr | output | 17 | Translated physical RAM address |
| ramEn | output | 1 | RAM enable for lower-half accesses |
| regRdData | output | 8 | Readback of the addressed selector |

## Verification
The hardest case to reach is the wrap at the top of RAM. It needs a window selector of $C1 or above together with a CPU address near $7FFF. It also needs the neighbouring case, $C0, which reaches exactly $1FFFF without wrapping. The vector table therefore loads both selectors through the real write path before each lookup. It places entries on each side of the wrap boundary, and one where the sum lands exactly on 2^17. Directed tests then hold the write conditions with phase 2 high, use aliased slot offsets, and issue read cycles, checking readback after each.

// File: rtl/lowmem_window_pkg.sv
package lowmem_window_pkg;
  localparam int SEL_COUNT = 2;
  localparam int PAGE_IDX  = 0;
  localparam int WIN_IDX   = 1;

  typedef struct packed {
    logic [SEL_COUNT-1:0] wrEn;
    logic                 rdIdx;
  } xlate_strobe_t;
endpackage

// File: rtl/lowmem_window_ctrl.sv
module lowmem_window_ctrl
  import lowmem_window_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuAddrHi,
  input  logic          regSelBit,
  input  logic          cpuRnW,
  input  logic          cpuPhi2,
  input  logic          ioSlotSel,
  output xlate_strobe_t strobe,
  output logic          ramEn
);
  logic phi2Q;
  logic phi2Fall;
  logic wrCycle;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phi2Q <= 1'b0;
    else       phi2Q <= cpuPhi2;
  end

  assign phi2Fall = phi2Q & ~cpuPhi2;
  assign wrCycle  = phi2Fall & ioSlotSel & ~cpuRnW;

  for (genvar g = 0; g < SEL_COUNT; g++) begin : g_wr
    assign strobe.wrEn[g] = wrCycle & (regSelBit == 1'(g));
  end

  assign strobe.rdIdx = regSelBit;
  assign ramEn        = ~cpuAddrHi & cpuPhi2;

  // R6: at most one selector written per cycle
  p_one_target_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.wrEn));
  // R6: a write only ever follows a falling phase-2 strobe
  p_write_on_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (|strobe.wrEn) |-> $fell(cpuPhi2));
  // R7: read cycles never write
  p_read_no_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    cpuRnW |-> (strobe.wrEn == '0));
  // R9: upper half never enables RAM
  p_upper_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    cpuAddrHi |-> !ramEn);
endmodule

// File: rtl/lowmem_window_dp.sv
module lowmem_window_dp
  import lowmem_window_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 8,
  parameter int PAGE_W = 9,
  localparam int PHYS_W = SEL_W + PAGE_W,
  localparam int WIN_W  = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlate_strobe_t     strobe,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [SEL_W-1:0]  cpuDataIn,
  output logic [PHYS_W-1:0] ramAddr,
  output logic [SEL_W-1:0]  regRdData
);
  logic [SEL_W-1:0]  selReg [SEL_COUNT];
  logic              inPageRegion;
  logic [PHYS_W-1:0] pagePhys;
  logic [PHYS_W-1:0] winBase;
  logic [PHYS_W-1:0] winPhys;

  for (genvar g = 0; g < SEL_COUNT; g++) begin : g_sel
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              selReg[g] <= '0;
      else if (strobe.wrEn[g]) selReg[g] <= cpuDataIn;
    end

    // R6: written value lands in the addressed selector
    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rstN)
      strobe.wrEn[g] |=> (selReg[g] == $past(cpuDataIn)));
    // R7: selector holds without its write strobe
    p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.wrEn[g] |=> $stable(selReg[g]));
  end

  assign inPageRegion = (cpuAddr[WIN_W-1:PAGE_W] == '0);
  assign pagePhys     = {selReg[PAGE_IDX], cpuAddr[PAGE_W-1:0]};
  assign winBase      = {selReg[WIN_IDX], {PAGE_W{1'b0}}};
  assign winPhys      = winBase + PHYS_W'(cpuAddr[WIN_W-1:0]);

  always_comb begin
    if (inPageRegion) ramAddr = pagePhys;
    else              ramAddr = winPhys;
  end

  assign regRdData = selReg[strobe.rdIdx];

  // R2: low offset bits pass straight through in the page region
  p_page_offset_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuAddr[ADDR_W-1] && inPageRegion) |-> (ramAddr[PAGE_W-1:0] == cpuAddr[PAGE_W-1:0]));
  // R5: windows based at $C0 or below never wrap under their base
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuAddr[ADDR_W-1] && !inPageRegion && selReg[WIN_IDX] <= SEL_W'(8'hC0))
      |-> (ramAddr >= winBase));
endmodule

// File: rtl/lowmem_window_mapper.sv
module lowmem_window_mapper
  import lowmem_window_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEL_W  = 8,
  parameter int PAGE_W = 9,
  localparam int PHYS_W = SEL_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [SEL_W-1:0]  cpuDataIn,
  input  logic              cpuRnW,
  input  logic              cpuPhi2,
  input  logic              ioSlotSel,
  output logic [PHYS_W-1:0] ramAddr,
  output logic              ramEn,
  output logic [SEL_W-1:0]  regRdData
);
  xlate_strobe_t strobe;

  lowmem_window_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuAddrHi (cpuAddr[ADDR_W-1]),
    .regSelBit (cpuAddr[0]),
    .cpuRnW    (cpuRnW),
    .cpuPhi2   (cpuPhi2),
    .ioSlotSel (ioSlotSel),
    .strobe    (strobe),
    .ramEn     (ramEn)
  );

  lowmem_window_dp #(
    .ADDR_W (ADDR_W),
    .SEL_W  (SEL_W),
    .PAGE_W (PAGE_W)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cpuAddr   (cpuAddr),
    .cpuDataIn (cpuDataIn),
    .ramAddr   (ramAddr),
    .regRdData (regRdData)
  );

  // R9: RAM is enabled only inside phase 2
  p_en_in_phi2_r9: assert property (@(posedge clk) disable iff (!rstN)
    ramEn |-> cpuPhi2);
endmodule

// File: tb/test_lowmem_window_mapper.sv
module test_lowmem_window_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 15;

  // fields: req code(2) | page sel(8) | window sel(8) | cpu addr(16) | expected phys(17)
  // req code: 0=R2 1=R3 2=R4 3=R5
  localparam logic [50:0] VEC [NVEC] = '{
    {2'd1, 8'h00, 8'h00, 16'h7FFF, 17'h07FFF},
    {2'd0, 8'h00, 8'h00, 16'h0000, 17'h00000},
    {2'd0, 8'h05, 8'h00, 16'h01FF, 17'h00BFF},
    {2'd0, 8'h05, 8'h00, 16'h0123, 17'h00B23},
    {2'd1, 8'h00, 8'h03, 16'h0200, 17'h00800},
    {2'd1, 8'h00, 8'h03, 16'h4000, 17'h04600},
    {2'd2, 8'h10, 8'h10, 16'h0000, 17'h02000},
    {2'd2, 8'h10, 8'h10, 16'h01FF, 17'h021FF},
    {2'd2, 8'h10, 8'h10, 16'h0200, 17'h02200},
    {2'd2, 8'h10, 8'h10, 16'h7FFF, 17'h09FFF},
    {2'd3, 8'h00, 8'hC0, 16'h7FFF, 17'h1FFFF},
    {2'd3, 8'h00, 8'hC1, 16'h7DFF, 17'h1FFFF},
    {2'd3, 8'h00, 8'hC1, 16'h7FFF, 17'h001FF},
    {2'd3, 8'h00, 8'hFF, 16'h0200, 17'h00000},
    {2'd0, 8'hFF, 8'hFF, 16'h01FF, 17'h1FFFF}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuDataIn = '0;
  logic        cpuRnW = 1'b1;
  logic        cpuPhi2 = 1'b0;
  logic        ioSlotSel = 1'b0;
  logic [16:0] ramAddr;
  logic        ramEn;
  logic [7:0]  regRdData;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lowmem_window_mapper i_lowmem_window_mapper (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuDataIn(cpuDataIn),
    .cpuRnW(cpuRnW), .cpuPhi2(cpuPhi2), .ioSlotSel(ioSlotSel),
    .ramAddr(ramAddr), .ramEn(ramEn), .regRdData(regRdData)
  );

  task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wrReg(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuAddr = a; cpuDataIn = d; cpuRnW = 1'b0; ioSlotSel = 1'b1; cpuPhi2 = 1'b1;
    @(negedge clk);
    cpuPhi2 = 1'b0;
    @(negedge clk);
    ioSlotSel = 1'b0; cpuRnW = 1'b1;
  endtask

  task automatic readSel(input logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    cpuAddr = a; cpuRnW = 1'b1; cpuPhi2 = 1'b1;
    #2 v = regRdData;
  endtask

  task automatic lookup(input logic [15:0] a, output logic [16:0] p);
    @(negedge clk);
    cpuAddr = a; cpuRnW = 1'b1; ioSlotSel = 1'b0; cpuPhi2 = 1'b1;
    #2 p = ramAddr;
  endtask

  function automatic string reqName(input logic [1:0] c);
    case (c)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [16:0] p;
    logic [7:0]  v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    readSel(16'hD000, v); check("R1 page sel", 17'(v), 17'h0);
    readSel(16'hD001, v); check("R1 window sel", 17'(v), 17'h0);
    lookup(16'h1234, p);  check("R1 identity", p, 17'h01234);

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0]  rc;
      logic [7:0]  pg, wn;
      logic [15:0] a;
      logic [16:0] e;
      {rc, pg, wn, a, e} = VEC[i];
      wrReg(16'hD000, pg);
      wrReg(16'hD001, wn);
      lookup(a, p);
      check(reqName(rc), p, e);
    end

    // R6: aliased offsets, bit 0 picks the target
    wrReg(16'hD0F3, 8'h22);
    readSel(16'hD001, v); check("R6 alias window", 17'(v), 17'h22);
    wrReg(16'hD0AA, 8'h07);
    readSel(16'hD000, v); check("R6 alias page", 17'(v), 17'h07);
    lookup(16'h0200, p);  check("R6 new window used", p, 17'h04600);

    // R7: read cycle with slot selected does not write
    @(negedge clk);
    cpuAddr = 16'hD001; cpuDataIn = 8'h99; cpuRnW = 1'b1; ioSlotSel = 1'b1; cpuPhi2 = 1'b1;
    @(negedge clk); cpuPhi2 = 1'b0;
    @(negedge clk); ioSlotSel = 1'b0;
    readSel(16'hD001, v); check("R7 read no write", 17'(v), 17'h22);

    // R7: slot not selected does not write
    @(negedge clk);
    cpuAddr = 16'hD000; cpuDataIn = 8'h55; cpuRnW = 1'b0; ioSlotSel = 1'b0; cpuPhi2 = 1'b1;
    @(negedge clk); cpuPhi2 = 1'b0;
    @(negedge clk); cpuRnW = 1'b1;
    readSel(16'hD000, v); check("R7 unselected no write", 17'(v), 17'h07);

    // R7: phase 2 held high does not write; the fall then commits (R6)
    @(negedge clk);
    cpuAddr = 16'hD000; cpuDataIn = 8'h3C; cpuRnW = 1'b0; ioSlotSel = 1'b1; cpuPhi2 = 1'b1;
    repeat (3) @(negedge clk);
    #2 check("R7 phi2 high holds", 17'(regRdData), 17'h07);
    @(negedge clk); cpuPhi2 = 1'b0;
    @(negedge clk); ioSlotSel = 1'b0; cpuRnW = 1'b1;
    #2 check("R6 commit on fall", 17'(regRdData), 17'h3C);

    // R8: readback follows address bit 0
    readSel(16'hD002, v); check("R8 readback even", 17'(v), 17'h3C);
    readSel(16'hD003, v); check("R8 readback odd", 17'(v), 17'h22);

    // R9: RAM enable
    @(negedge clk); cpuAddr = 16'h8000; cpuPhi2 = 1'b1;
    #2 check("R9 upper half", 17'(ramEn), 17'h0);
    @(negedge clk); cpuAddr = 16'h4000; cpuPhi2 = 1'b0;
    #2 check("R9 phi2 low", 17'(ramEn), 17'h0);
    @(negedge clk); cpuPhi2 = 1'b1;
    #2 check("R9 enabled", 17'(ramEn), 17'h1);

    // R1: reset mid-run restores identity
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    lookup(16'h7ABC, p);  check("R1 reset identity", p, 17'h07ABC);
    readSel(16'hD000, v); check("R1 reset page sel", 17'(v), 17'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule